// File: doc/BRIEF.md
# Bus-Request Interrupt Level Arbiter

This block gathers the interrupt request lines of the devices that sit behind two bus adapters. It turns them into the bitmap of CPU priority-interrupt levels that the CPU's interrupt unit evaluates, and it answers the CPU's vector fetch for a level that has been granted. Each request line belongs to one adapter, and within that adapter to either the urgent group (bus priorities 7 and 6) or the routine group (bus priorities 5 and 4). The group membership is fixed by parameter masks. Each adapter has a status register, and that register holds one programmable CPU level for its urgent group and one for its routine group.

When the CPU acknowledges a level, the block answers one cycle later. Adapters are searched in index order, and within an adapter the urgent group is searched before the routine group. In the first group whose level matches and that has requests pending, the lowest-numbered pending line wins. That line's request is withdrawn, and its vector is returned from a programmable table. An odd adapter number is reported with the vector. The acknowledge path is a two-state machine: `ST_IDLE` (no response shown) and `ST_RESP` (response shown for one cycle). Each transition is named for its cause: IDLE->RESP on an acknowledge request, RESP->RESP on a back-to-back request, and RESP->IDLE when no request arrives.

Top module: `irq_level_arbiter`

## Requirements
- R1: A one-cycle pulse on `req_set[i]` makes line i pending. A pending line stays pending until an acknowledge selects it. A set and a clear of the same line in the same cycle leave the line pending.
- R2: `lvl_map` bit n is 1 exactly when some adapter has a pending line in a group whose programmed level is n. Level 0 adds nothing, so bit 0 is always 0.
- R3: On acknowledge, adapters are searched from index 0 upward, and within each adapter the urgent group is searched before the routine group. The first group whose level equals `ack_lvl` and that has pending lines is chosen. An `ack_lvl` of 0 matches nothing.
- R4: Within the chosen group, the lowest-numbered pending line wins. Its pending state is cleared at the same edge that registers the response.
- R5: `ack_adp` reports the chosen adapter index a as 2a+1, giving 1 and 3.
- R6: `ack_valid` is 1 in the cycle after each cycle with `ack_req` high, and 0 otherwise. While `ack_valid` is 0, `ack_vec` and `ack_adp` are 0.
- R7: When no group matches, `ack_vec` is 0 and `ack_adp` is 2*NUM_ADP+1, which is 5.
- R8: The status layout is bits[2:0] routine level, bits[5:3] urgent level, bit6 transfer-disable, bit7 init (write-only, reads 0), bit8 routine-pending, bit9 urgent-pending, and bit10 fault (read-to-zero). `csr_rdata` shows the selected adapter with the pending flags ORed with the live group state. A read stores those flags and clears the fault. A `fault_set` pulse sets the fault, and a set wins over a read in the same cycle.
- R9: A write with bit7 set keeps only bit6 of the write data and pulses that adapter's `dev_init` for one cycle. Any other write stores bits[6:0]. After either kind of write, the pending flags are reloaded from the live group state and the fault bit is cleared unless `fault_set` arrives in the same cycle.
- R10: Reset clears all pending lines, both status registers, the vector table and the response.
- R11: `vec_we` writes `vec_wdata` into the table entry for line `vec_idx`. An acknowledge in the same cycle reads the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set | input | 32 | Request set pulses, one per line |
| fault_set | input | 2 | Fault set pulse, one per adapter |
| csr_sel | input | 1 | Adapter selected for status access |
| csr_rd | input | 1 | Status read strobe |
| csr_wr | input | 1 | Status write strobe |
| csr_wdata | input | 12 | Status write data |
| csr_rdata | output | 12 | Status view of the selected adapter |
| vec_we | input | 1 | Vector table write strobe |
| vec_idx | input | 5 | Vector table entry |
| vec_wdata | input | 9 | Vector table write data |
| ack_req | input | 1 | CPU vector acknowledge request |
| ack_lvl | input | 3 | Level being acknowledged |
| lvl_map | output | 8 | Requested CPU levels, one bit per level |
| ack_valid | output | 1 | Response present |
| ack_vec | output | 9 | Returned vector |
| ack_adp | output | 3 | Adapter number (odd) |
| dev_init | output | 2 | Downstream init pulse, one per adapter |

## Verification
The bench builds the block with its defaults: two adapters, 32 lines, and masks that put adapter 0's routine group on the lines below its urgent group. That ordering lets the bench tell the urgent-before-routine rule apart from the lowest-line rule. Both adapters can be programmed to the same level, which brings the adapter-order rule within reach. Acknowledges at level 0, at unprogrammed levels and back to back are generated in the random phase, together with status reads, init writes and fault pulses that collide in the same cycle.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;
    localparam int LVL_W  = 3;
    localparam int MAP_W  = 1 << LVL_W;
    localparam int STAT_W = 12;
    localparam int B_LO   = 0;
    localparam int B_HI   = 3;
    localparam int B_XOFF = 6;
    localparam int B_INIT = 7;
    localparam int B_LOP  = 8;
    localparam int B_HIP  = 9;
    localparam int B_FLT  = 10;

    typedef enum logic {ST_IDLE = 1'b0, ST_RESP = 1'b1} ack_state_e;
endpackage

// File: rtl/irq_adp_csr.sv
`timescale 1ns/1ps
module irq_adp_csr
    import irq_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              wr,
    input  logic [STAT_W-1:0] wdata,
    input  logic              hi_any,
    input  logic              lo_any,
    input  logic              fault_set,
    output logic [STAT_W-1:0] view,
    output logic [LVL_W-1:0]  hi_lvl,
    output logic [LVL_W-1:0]  lo_lvl,
    output logic              init_pulse
);
    localparam logic [STAT_W-1:0] WR_MASK   = STAT_W'((1 << B_INIT) - 1);
    localparam logic [STAT_W-1:0] XOFF_MASK = STAT_W'(1 << B_XOFF);

    logic [STAT_W-1:0] stat_q, stat_d;

    always_comb begin
        view        = stat_q;
        view[B_HIP] = stat_q[B_HIP] | hi_any;
        view[B_LOP] = stat_q[B_LOP] | lo_any;
        stat_d      = stat_q;
        if (wr) begin
            stat_d        = wdata & (wdata[B_INIT] ? XOFF_MASK : WR_MASK);
            stat_d[B_HIP] = hi_any;
            stat_d[B_LOP] = lo_any;
        end else if (rd) begin
            stat_d        = view;
            stat_d[B_FLT] = 1'b0;
        end
        if (fault_set) stat_d[B_FLT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q     <= '0;
            init_pulse <= 1'b0;
        end else begin
            stat_q     <= stat_d;
            init_pulse <= wr & wdata[B_INIT];
        end
    end

    assign hi_lvl = stat_q[B_HI +: LVL_W];
    assign lo_lvl = stat_q[B_LO +: LVL_W];

    assert_init_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[B_INIT]) |=> (init_pulse && hi_lvl == '0 && lo_lvl == '0));
    assert_read_clears_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr && !fault_set) |=> !view[B_FLT]);
endmodule

// File: rtl/irq_lvl_merge.sv
`timescale 1ns/1ps
module irq_lvl_merge
    import irq_arb_pkg::*;
#(
    parameter int NUM_ADP = 2
) (
    input  logic [NUM_ADP-1:0]            hi_any,
    input  logic [NUM_ADP-1:0]            lo_any,
    input  logic [NUM_ADP-1:0][LVL_W-1:0] hi_lvl,
    input  logic [NUM_ADP-1:0][LVL_W-1:0] lo_lvl,
    output logic [MAP_W-1:0]              lvl_map
);
    always_comb begin
        lvl_map = '0;
        for (int a = 0; a < NUM_ADP; a++) begin
            if (hi_any[a]) lvl_map[hi_lvl[a]] = 1'b1;
            if (lo_any[a]) lvl_map[lo_lvl[a]] = 1'b1;
        end
        lvl_map[0] = 1'b0;
    end
endmodule

// File: rtl/irq_ack_pick.sv
`timescale 1ns/1ps
module irq_ack_pick
    import irq_arb_pkg::*;
#(
    parameter int NUM_REQ = 32,
    parameter int NUM_ADP = 2,
    parameter logic [NUM_ADP*NUM_REQ-1:0] HI_MASKS = '0,
    parameter logic [NUM_ADP*NUM_REQ-1:0] LO_MASKS = '0,
    localparam int RIX_W  = $clog2(NUM_REQ),
    localparam int ADPN_W = $clog2(2*NUM_ADP+2)
) (
    input  logic [NUM_REQ-1:0]            pend,
    input  logic [NUM_ADP-1:0][LVL_W-1:0] hi_lvl,
    input  logic [NUM_ADP-1:0][LVL_W-1:0] lo_lvl,
    input  logic [LVL_W-1:0]              ack_lvl,
    output logic                          hit,
    output logic [RIX_W-1:0]              hit_idx,
    output logic [ADPN_W-1:0]             hit_adp
);
    logic [NUM_REQ-1:0] sel;
    logic               chosen;
    logic               found;

    always_comb begin
        sel     = '0;
        chosen  = 1'b0;
        hit_adp = ADPN_W'(2*NUM_ADP+1);
        for (int a = 0; a < NUM_ADP; a++) begin
            if (!chosen && ack_lvl != '0) begin
                if (ack_lvl == hi_lvl[a] && |(pend & HI_MASKS[a*NUM_REQ +: NUM_REQ])) begin
                    sel     = pend & HI_MASKS[a*NUM_REQ +: NUM_REQ];
                    chosen  = 1'b1;
                    hit_adp = ADPN_W'(2*a+1);
                end else if (ack_lvl == lo_lvl[a] && |(pend & LO_MASKS[a*NUM_REQ +: NUM_REQ])) begin
                    sel     = pend & LO_MASKS[a*NUM_REQ +: NUM_REQ];
                    chosen  = 1'b1;
                    hit_adp = ADPN_W'(2*a+1);
                end
            end
        end
        found   = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (!found && sel[i]) begin
                hit_idx = RIX_W'(i);
                found   = 1'b1;
            end
        end
        hit = found;
    end
endmodule

// File: rtl/irq_level_arbiter.sv
`timescale 1ns/1ps
module irq_level_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_REQ = 32,
    parameter int NUM_ADP = 2,
    parameter int VEC_W   = 9,
    parameter logic [NUM_ADP*NUM_REQ-1:0] HI_MASKS = {32'h0000_FF00, 32'h0000_00F0},
    parameter logic [NUM_ADP*NUM_REQ-1:0] LO_MASKS = {32'hFFFF_0000, 32'h0000_000F},
    localparam int SEL_W  = (NUM_ADP > 1) ? $clog2(NUM_ADP) : 1,
    localparam int RIX_W  = $clog2(NUM_REQ),
    localparam int ADPN_W = $clog2(2*NUM_ADP+2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_set,
    input  logic [NUM_ADP-1:0] fault_set,
    input  logic [SEL_W-1:0]   csr_sel,
    input  logic               csr_rd,
    input  logic               csr_wr,
    input  logic [STAT_W-1:0]  csr_wdata,
    output logic [STAT_W-1:0]  csr_rdata,
    input  logic               vec_we,
    input  logic [RIX_W-1:0]   vec_idx,
    input  logic [VEC_W-1:0]   vec_wdata,
    input  logic               ack_req,
    input  logic [LVL_W-1:0]   ack_lvl,
    output logic [MAP_W-1:0]   lvl_map,
    output logic               ack_valid,
    output logic [VEC_W-1:0]   ack_vec,
    output logic [ADPN_W-1:0]  ack_adp,
    output logic [NUM_ADP-1:0] dev_init
);
    localparam logic [ADPN_W-1:0] NOADP = ADPN_W'(2*NUM_ADP+1);

    logic [NUM_REQ-1:0]            pend_q, clr_vec;
    logic [NUM_ADP-1:0]            hi_any, lo_any;
    logic [NUM_ADP-1:0][LVL_W-1:0] hi_lvl, lo_lvl;
    logic [STAT_W-1:0]             views [NUM_ADP];
    logic [VEC_W-1:0]              vtab [NUM_REQ];
    logic                          pick_hit;
    logic [RIX_W-1:0]              pick_idx;
    logic [ADPN_W-1:0]             pick_adp;
    ack_state_e                    state_q, state_d;
    logic [VEC_W-1:0]              res_vec;
    logic [ADPN_W-1:0]             res_adp;

    for (genvar a = 0; a < NUM_ADP; a++) begin : g_adp
        assign hi_any[a] = |(pend_q & HI_MASKS[a*NUM_REQ +: NUM_REQ]);
        assign lo_any[a] = |(pend_q & LO_MASKS[a*NUM_REQ +: NUM_REQ]);
        irq_adp_csr u_csr (
            .clk        (clk),
            .rst_n      (rst_n),
            .rd         (csr_rd && csr_sel == SEL_W'(a)),
            .wr         (csr_wr && csr_sel == SEL_W'(a)),
            .wdata      (csr_wdata),
            .hi_any     (hi_any[a]),
            .lo_any     (lo_any[a]),
            .fault_set  (fault_set[a]),
            .view       (views[a]),
            .hi_lvl     (hi_lvl[a]),
            .lo_lvl     (lo_lvl[a]),
            .init_pulse (dev_init[a])
        );
    end

    assign csr_rdata = views[csr_sel];

    irq_lvl_merge #(.NUM_ADP(NUM_ADP)) u_merge (
        .hi_any  (hi_any),
        .lo_any  (lo_any),
        .hi_lvl  (hi_lvl),
        .lo_lvl  (lo_lvl),
        .lvl_map (lvl_map)
    );

    irq_ack_pick #(
        .NUM_REQ  (NUM_REQ),
        .NUM_ADP  (NUM_ADP),
        .HI_MASKS (HI_MASKS),
        .LO_MASKS (LO_MASKS)
    ) u_pick (
        .pend    (pend_q),
        .hi_lvl  (hi_lvl),
        .lo_lvl  (lo_lvl),
        .ack_lvl (ack_lvl),
        .hit     (pick_hit),
        .hit_idx (pick_idx),
        .hit_adp (pick_adp)
    );

    always_comb begin
        clr_vec = '0;
        if (ack_req && pick_hit) clr_vec[pick_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            for (int i = 0; i < NUM_REQ; i++) vtab[i] <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_vec) | req_set;
            if (vec_we) vtab[vec_idx] <= vec_wdata;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = ack_req ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = ack_req ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            res_vec <= '0;
            res_adp <= '0;
        end else begin
            state_q <= state_d;
            if (ack_req) begin
                res_vec <= pick_hit ? vtab[pick_idx] : '0;
                res_adp <= pick_adp;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_RESP: begin
                ack_valid = 1'b1;
                ack_vec   = res_vec;
                ack_adp   = res_adp;
            end
            default: begin
                ack_valid = 1'b0;
                ack_vec   = '0;
                ack_adp   = '0;
            end
        endcase
    end

    assert_ack_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> ack_valid);
    assert_ack_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_req |=> (!ack_valid && ack_vec == '0));
    assert_adp_odd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> ack_adp[0]);
    assert_nomatch_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_adp == NOADP) |-> ack_vec == '0);
    assert_win_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && pick_hit && !req_set[pick_idx]) |=> !pend_q[$past(pick_idx)]);
    assert_set_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_set) |=> ((pend_q & $past(req_set)) == $past(req_set)));
endmodule

// File: tb/irq_level_arbiter_test.sv
`timescale 1ns/1ps
module irq_level_arbiter_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] req_set;
    logic [1:0]  fault_set;
    logic        csr_sel, csr_rd, csr_wr;
    logic [11:0] csr_wdata;
    logic [11:0] csr_rdata;
    logic        vec_we;
    logic [4:0]  vec_idx;
    logic [8:0]  vec_wdata;
    logic        ack_req;
    logic [2:0]  ack_lvl;
    logic [7:0]  lvl_map;
    logic        ack_valid;
    logic [8:0]  ack_vec;
    logic [2:0]  ack_adp;
    logic [1:0]  dev_init;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_level_arbiter uut (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .fault_set(fault_set),
        .csr_sel(csr_sel), .csr_rd(csr_rd), .csr_wr(csr_wr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .vec_we(vec_we), .vec_idx(vec_idx), .vec_wdata(vec_wdata),
        .ack_req(ack_req), .ack_lvl(ack_lvl), .lvl_map(lvl_map),
        .ack_valid(ack_valid), .ack_vec(ack_vec), .ack_adp(ack_adp),
        .dev_init(dev_init)
    );

    // reference model state
    bit [31:0] hi_m [2] = '{32'h0000_00F0, 32'h0000_FF00};
    bit [31:0] lo_m [2] = '{32'h0000_000F, 32'hFFFF_0000};
    bit [31:0] m_pend;
    bit [11:0] m_stat [2];
    bit [8:0]  m_vt [32];
    bit        m_valid;
    bit [8:0]  m_vec;
    bit [2:0]  m_adp;
    bit [1:0]  m_init;

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic bit [11:0] m_view(int a);
        bit [11:0] v = m_stat[a];
        if ((m_pend & hi_m[a]) != 0) v[9] = 1'b1;
        if ((m_pend & lo_m[a]) != 0) v[8] = 1'b1;
        return v;
    endfunction

    task automatic model_edge();
        bit [31:0] win;
        int        idx;
        bit [11:0] nstat [2];
        if (!rst_n) begin
            m_pend = 0; m_stat[0] = 0; m_stat[1] = 0;
            foreach (m_vt[i]) m_vt[i] = 0;
            m_valid = 0; m_vec = 0; m_adp = 0; m_init = 0;
            return;
        end
        win = 0; idx = -1;
        m_valid = ack_req;
        if (ack_req) begin
            m_adp = 5;
            for (int a = 0; a < 2; a++) begin
                int hl = (m_stat[a] >> 3) & 7;
                int ll = m_stat[a] & 7;
                if (win == 0 && ack_lvl != 0) begin
                    if (ack_lvl == hl && (m_pend & hi_m[a]) != 0) begin
                        win = m_pend & hi_m[a]; m_adp = 3'(2*a+1);
                    end else if (ack_lvl == ll && (m_pend & lo_m[a]) != 0) begin
                        win = m_pend & lo_m[a]; m_adp = 3'(2*a+1);
                    end
                end
            end
            for (int i = 31; i >= 0; i--) if (win[i]) idx = i;
            m_vec = (idx >= 0) ? m_vt[idx] : 9'd0;
        end else begin
            m_vec = 0; m_adp = 0;
        end
        for (int a = 0; a < 2; a++) begin
            nstat[a] = m_stat[a];
            m_init[a] = 0;
            if (csr_wr && csr_sel == a) begin
                if (csr_wdata[7]) begin
                    nstat[a] = csr_wdata & 12'h040; m_init[a] = 1;
                end else nstat[a] = csr_wdata & 12'h07F;
                nstat[a][9] = (m_pend & hi_m[a]) != 0;
                nstat[a][8] = (m_pend & lo_m[a]) != 0;
            end else if (csr_rd && csr_sel == a) begin
                nstat[a] = m_view(a);
                nstat[a][10] = 0;
            end
            if (fault_set[a]) nstat[a][10] = 1;
        end
        m_stat[0] = nstat[0]; m_stat[1] = nstat[1];
        if (idx >= 0) m_pend[idx] = 0;
        m_pend |= req_set;
        if (vec_we) m_vt[vec_idx] = vec_wdata;
    endtask

    task automatic compare();
        bit [7:0] em = 0;
        for (int a = 0; a < 2; a++) begin
            if ((m_pend & hi_m[a]) != 0) em[(m_stat[a] >> 3) & 7] = 1;
            if ((m_pend & lo_m[a]) != 0) em[m_stat[a] & 7] = 1;
        end
        em[0] = 0;
        chk("R2 lvl_map", lvl_map, em);
        chk("R6 ack_valid", ack_valid, m_valid);
        chk("R4 ack_vec", ack_vec, m_vec);
        chk("R5 ack_adp", ack_adp, m_adp);
        chk("R9 dev_init", dev_init, m_init);
        chk("R8 csr_rdata", csr_rdata, m_view(csr_sel));
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #2;
        compare();
    endtask

    task automatic idle();
        req_set = 0; fault_set = 0; csr_sel = 0; csr_rd = 0; csr_wr = 0;
        csr_wdata = 0; vec_we = 0; vec_idx = 0; vec_wdata = 0;
        ack_req = 0; ack_lvl = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) step();
        rst_n = 1;
        step();
        chk("R10 reset lvl_map", lvl_map, 0);
        chk("R10 reset csr_rdata", csr_rdata, 0);
        chk("R10 reset ack_valid", ack_valid, 0);

        for (int i = 0; i < 32; i++) begin
            vec_we = 1; vec_idx = 5'(i); vec_wdata = 9'(64 + 4*i);
            step();
        end
        idle();
        csr_wr = 1; csr_sel = 0; csr_wdata = 12'h02A; step();   // urgent 5, routine 2
        csr_sel = 1; csr_wdata = 12'h02B; step();               // urgent 5, routine 3
        idle();
        req_set = (32'd1 << 4) | (32'd1 << 9); step();
        chk("R2 both urgent at level 5", lvl_map, 8'h20);
        idle();
        ack_req = 1; ack_lvl = 5; req_set = 32'd1 << 4; step();
        chk("R3 adapter 0 first vec", ack_vec, 80);
        chk("R3 adapter 0 first adp", ack_adp, 1);
        req_set = 0; step();
        chk("R1 set wins over clear", ack_vec, 80);
        step();
        chk("R5 adapter 1 vec", ack_vec, 100);
        chk("R5 adapter 1 adp", ack_adp, 3);
        ack_lvl = 7; step();
        chk("R7 no match vec", ack_vec, 0);
        chk("R7 no match adp", ack_adp, 5);
        idle(); step();
        chk("R6 idle after response", ack_valid, 0);

        csr_wr = 1; csr_sel = 0; csr_wdata = 12'h024; step();   // urgent 4, routine 4
        idle();
        req_set = (32'd1 << 1) | (32'd1 << 6); step();
        idle();
        ack_req = 1; ack_lvl = 4; step();
        chk("R3 urgent before routine", ack_vec, 88);
        step();
        chk("R4 routine line next", ack_vec, 68);
        idle();
        fault_set = 2'b01; step();
        chk("R8 fault visible", csr_rdata[10], 1);
        fault_set = 0; csr_rd = 1; step();
        chk("R8 fault cleared by read", csr_rdata[10], 0);
        idle();
        csr_wr = 1; csr_wdata = 12'h0FF; step();
        chk("R9 init pulse", dev_init, 2'b01);
        chk("R9 init keeps only disable bit", csr_rdata[7:0], 8'h40);
        idle();
        vec_we = 1; vec_idx = 9; vec_wdata = 9'h1A5; step();
        idle();
        req_set = 32'd1 << 9; step();
        idle();
        ack_req = 1; ack_lvl = 5; step();
        chk("R11 rewritten vector", ack_vec, 9'h1A5);
        chk("R11 rewritten vector adp", ack_adp, 3);
        idle();

        for (int n = 0; n < 4000; n++) begin
            req_set   = $urandom & $urandom & $urandom;
            fault_set = 2'($urandom % 4 == 0 ? $urandom : 0);
            csr_sel   = 1'($urandom);
            csr_rd    = ($urandom % 4) == 0;
            csr_wr    = ($urandom % 6) == 0;
            csr_wdata = 12'($urandom);
            if ($urandom % 5 != 0) csr_wdata[7] = 1'b0;
            vec_we    = ($urandom % 4) == 0;
            vec_idx   = 5'($urandom);
            vec_wdata = 9'($urandom);
            ack_req   = ($urandom % 2) == 0;
            ack_lvl   = 3'($urandom);
            rst_n     = ($urandom % 500) != 0;
            step();
        end
        rst_n = 1;
        idle();
        step();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule